// File: doc/BRIEF.md
# Branch Target Cache

This block remembers where recently seen taken branches go. The fetch stage presents its current fetch address on the lookup port every cycle. Every valid slot compares its stored branch address against that address at the same time. On a match, the block returns the stored destination in the same cycle, so fetch can steer to the destination on the very next clock with no lost slot.

The prediction logic maintains the contents through a single update port. The port carries a branch address, its destination, and a flag that says whether the branch is now expected to be taken. An update flagged taken installs the branch, or refreshes its destination if the branch is already present. An update flagged not taken removes the branch if it is present. As a result, only branches expected to be taken ever occupy a slot. When every slot is busy, a rotating pointer chooses which slot to overwrite. A synchronous flush input empties the whole table.

Top module: `branch_target_cache`

## Requirements
- R1: After synchronous reset every slot is empty, every lookup misses (`lk_hit`=0), and the replacement pointer starts at slot 0.
- R2: When a valid slot holds the lookup address, `lk_hit` is 1 in the same cycle and `lk_target` equals that slot's stored destination. On a miss, `lk_target` is 0.
- R3: An update with `upd_valid`=1 and `upd_taken`=1 stores the branch at the next clock edge. A lookup of that address in the same cycle as the update still returns the old contents.
- R4: An update with `upd_valid`=1 and `upd_taken`=0 whose address is present empties that slot at the next edge. All other slots are unaffected.
- R5: An update with `upd_taken`=0 whose address is absent changes nothing. In particular, it never installs the branch.
- R6: A taken update whose address is already present rewrites that slot's destination in place. It uses no additional slot and does not move the replacement pointer.
- R7: A taken update for a new address goes to the lowest-numbered empty slot whenever one exists. The replacement pointer is left unchanged.
- R8: If no slot is empty, a taken update for a new address overwrites the slot named by the replacement pointer. The pointer then advances by one and wraps from ENTRIES-1 back to 0.
- R9: With `flush`=1, every slot is emptied at the next edge. Flush takes priority over an update presented in the same cycle, and that update is dropped.
- R10: No address is ever held by more than one slot, so at most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots at the next edge |
| lk_addr | input | AW | Fetch address to look up |
| lk_hit | output | 1 | A valid slot holds `lk_addr` |
| lk_target | output | AW | Stored destination on a hit, 0 otherwise |
| upd_valid | input | 1 | Update request present this cycle |
| upd_addr | input | AW | Branch address of the update |
| upd_target | input | AW | Destination to store |
| upd_taken | input | 1 | 1 = install or refresh, 0 = remove |

## Verification
The bench builds the block with ENTRIES=8 and AW=16 rather than the default of 32 slots. With only 8 slots, a handful of updates fills the table, so eviction through the rotating pointer comes within reach quickly. The smaller table also lets the bench drive the pointer through a full wrap. It also makes the choice between a hole left by a removal and the pointer's slot easy to observe. After every update, each address used so far is swept across the lookup port, so the whole table's contents are visible at the ports.

// File: rtl/btc_pkg.sv
package btc_pkg;

    // Action applied to the table at the next clock edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_DROP  = 2'd2,
        OP_CLEAR = 2'd3
    } tbl_op_e;

    // Flush dominates; otherwise the taken flag picks install or removal.
    function automatic tbl_op_e decode_op(input logic flush_i,
                                          input logic req_i,
                                          input logic taken_i);
        if (flush_i)      return OP_CLEAR;
        else if (!req_i)  return OP_IDLE;
        else if (taken_i) return OP_WRITE;
        else              return OP_DROP;
    endfunction

endpackage

// File: rtl/btc_match.sv
module btc_match #(
    parameter int ENTRIES = 32,
    parameter int AW      = 32
) (
    input  logic [ENTRIES-1:0]    valid,
    input  logic [ENTRIES*AW-1:0] tags,
    input  logic [AW-1:0]         key,
    output logic [ENTRIES-1:0]    hits
);
    // One comparator per slot, all in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = valid[g] && (tags[g*AW +: AW] == key);
    end
endmodule

// File: rtl/btc_alloc.sv
module btc_alloc #(
    parameter int ENTRIES = 32,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               take,
    output logic [IW-1:0]      slot_idx
);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;
    logic          any_free;

    // Lowest-numbered empty slot: scan downward so the smallest index wins.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
    end

    assign slot_idx = any_free ? free_idx : ptr_q;

    // The rotating pointer moves only when it actually supplies a victim.
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (take && !any_free)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    // R7: a chosen empty slot really is empty.
    p_free_slot_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (take && any_free) |-> !valid[slot_idx]);

    // R7/R8: the pointer stays put unless an eviction happens.
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!take || any_free) |=> $stable(ptr_q));

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
    parameter int ENTRIES = 32,
    parameter int AW      = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [AW-1:0] lk_target,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_addr,
    input  logic [AW-1:0] upd_target,
    input  logic          upd_taken
);
    import btc_pkg::*;

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]    valid_q;
    logic [AW-1:0]         tag_q [ENTRIES];
    logic [AW-1:0]         dst_q [ENTRIES];
    logic [ENTRIES*AW-1:0] tags_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tags_flat[g*AW +: AW] = tag_q[g];
    end

    // ---------------- lookup side (combinational) ----------------
    logic [ENTRIES-1:0] lk_hits;

    btc_match #(.ENTRIES(ENTRIES), .AW(AW)) u_lk_match (
        .valid(valid_q), .tags(tags_flat), .key(lk_addr), .hits(lk_hits)
    );

    // At most one slot matches, so an AND-OR mux selects the destination.
    always_comb begin
        lk_target = '0;
        for (int i = 0; i < ENTRIES; i++)
            lk_target |= lk_hits[i] ? dst_q[i] : '0;
    end
    assign lk_hit = |lk_hits;

    // ---------------- update side ----------------
    logic [ENTRIES-1:0] up_hits;
    logic [IW-1:0]      up_idx;
    logic [IW-1:0]      new_idx;
    logic [IW-1:0]      wr_idx;
    logic               up_present;
    logic               need_slot;
    tbl_op_e            op;

    btc_match #(.ENTRIES(ENTRIES), .AW(AW)) u_up_match (
        .valid(valid_q), .tags(tags_flat), .key(upd_addr), .hits(up_hits)
    );

    always_comb begin
        up_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (up_hits[i]) up_idx = IW'(i);
    end

    assign up_present = |up_hits;
    assign op         = decode_op(flush, upd_valid, upd_taken);
    assign need_slot  = (op == OP_WRITE) && !up_present;
    assign wr_idx     = up_present ? up_idx : new_idx;

    btc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk(clk), .rst(rst), .valid(valid_q), .take(need_slot), .slot_idx(new_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: valid_q <= '0;
                OP_DROP:  valid_q <= valid_q & ~up_hits;
                OP_WRITE: begin
                    valid_q[wr_idx] <= 1'b1;
                    tag_q[wr_idx]   <= upd_addr;
                    dst_q[wr_idx]   <= upd_target;
                end
                default: ;
            endcase
        end
    end

    // R10: never two slots for one address.
    p_single_match_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hits));

    // R9: after a flush nothing hits.
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R3: an installed branch is found with its destination one cycle later.
    p_install_visible_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !flush) |=>
            ((lk_addr != $past(upd_addr)) || (lk_hit && lk_target == $past(upd_target))));

    // R4: a removed branch misses one cycle later.
    p_remove_misses_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && !flush) |=>
            ((lk_addr != $past(upd_addr)) || !lk_hit));

endmodule

// File: tb/branch_target_cache_bench.sv
module branch_target_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int E  = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [AW-1:0] lk_target;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;

    branch_target_cache #(.ENTRIES(E), .AW(AW)) u_branch_target_cache (
        .clk(clk), .rst(rst), .flush(flush), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_target(lk_target), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_target(upd_target), .upd_taken(upd_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural reference table.
    bit            m_val [E];
    logic [AW-1:0] m_tag [E];
    logic [AW-1:0] m_dst [E];
    int            m_ptr = 0;
    logic [AW-1:0] seen[$];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < E; i++) if (m_val[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    task automatic expect_lookup(input string req);
        int k;
        logic          eh;
        logic [AW-1:0] et;
        k  = m_find(lk_addr);
        eh = (k >= 0);
        et = eh ? m_dst[k] : '0;
        checks++;
        if (lk_hit !== eh || lk_target !== et) begin
            errors++;
            $display("FAIL %s addr=%h actual hit=%b tgt=%h expected hit=%b tgt=%h",
                     req, lk_addr, lk_hit, lk_target, eh, et);
        end
    endtask

    task automatic model_step(input logic v, input logic tk, input logic fl,
                              input logic [AW-1:0] a, input logic [AW-1:0] t);
        int k;
        if (fl) begin
            for (int i = 0; i < E; i++) m_val[i] = 0;
        end else if (v) begin
            k = m_find(a);
            if (tk) begin
                if (k < 0) begin
                    for (int i = E - 1; i >= 0; i--) if (!m_val[i]) k = i;
                    if (k < 0) begin
                        k = m_ptr;
                        m_ptr = (m_ptr + 1) % E;
                    end
                end
                m_val[k] = 1; m_tag[k] = a; m_dst[k] = t;
            end else if (k >= 0) begin
                m_val[k] = 0;
            end
        end
    endtask

    // One clock: drive at the falling edge, check lookup, then commit the model.
    task automatic cyc(input logic v, input logic tk, input logic fl,
                       input logic [AW-1:0] a, input logic [AW-1:0] t,
                       input logic [AW-1:0] la, input string req);
        @(negedge clk);
        upd_valid = v; upd_taken = tk; flush = fl;
        upd_addr = a; upd_target = t; lk_addr = la;
        #1;
        expect_lookup(req);
        if (v) seen.push_back(a);
        @(posedge clk);
        model_step(v, tk, fl, a, t);
    endtask

    task automatic probe(input string req);
        foreach (seen[i]) cyc(1'b0, 1'b0, 1'b0, '0, '0, seen[i], req);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 16'h0999, req);
    endtask

    initial begin
        for (int i = 0; i < E; i++) m_val[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty after reset.
        cyc(0, 0, 0, '0, '0, 16'h0100, "R1");
        cyc(0, 0, 0, '0, '0, 16'h0000, "R1");

        // R3: same-cycle lookup of the address being installed sees the old state.
        cyc(1, 1, 0, 16'h0100, 16'h0900, 16'h0100, "R3");
        // R2: visible on the next cycle.
        cyc(0, 0, 0, '0, '0, 16'h0100, "R2");

        // R7: fill the remaining slots in order.
        for (int i = 1; i < E; i++)
            cyc(1, 1, 0, 16'h0100 + 16'(i * 16), 16'h0900 + 16'(i), 16'h0100, "R7");
        probe("R2");

        // R8: table full, evictions follow the pointer from slot 0.
        cyc(1, 1, 0, 16'h0200, 16'h0A00, 16'h0110, "R8");
        cyc(1, 1, 0, 16'h0210, 16'h0A10, 16'h0200, "R8");
        probe("R8");

        // R4: remove one branch, others stay.
        cyc(1, 0, 0, 16'h0130, '0, 16'h0130, "R4");
        probe("R4");

        // R7: hole left by the removal is used instead of the pointer's slot.
        cyc(1, 1, 0, 16'h0220, 16'h0A20, 16'h0220, "R7");
        probe("R7");

        // R6: refresh in place, no slot consumed, pointer untouched.
        cyc(1, 1, 0, 16'h0140, 16'h0BEE, 16'h0140, "R6");
        probe("R6");
        cyc(1, 1, 0, 16'h0230, 16'h0A30, 16'h0140, "R6");
        probe("R6");

        // R5: not-taken for an absent address is ignored.
        cyc(1, 0, 0, 16'h0555, 16'h0777, 16'h0555, "R5");
        probe("R5");

        // R8: wrap the pointer around the whole table.
        for (int i = 0; i < E + 3; i++)
            cyc(1, 1, 0, 16'h0300 + 16'(i * 16), 16'h0C00 + 16'(i), 16'h0300, "R8");
        probe("R8");

        // R10: lookups return exactly one slot's destination.
        cyc(1, 1, 0, 16'h0300 + 16'(E * 16), 16'h0D0D, 16'h0000, "R10");
        probe("R10");

        // R9: flush wins over a same-cycle install.
        cyc(1, 1, 1, 16'h0400, 16'h0E00, 16'h0300, "R9");
        probe("R9");

        // Refill after flush starts from slot 0 again.
        cyc(1, 1, 0, 16'h0410, 16'h0E10, 16'h0410, "R3");
        probe("R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule